// File: doc/BRIEF.md
# Sparsity-Aware Activation Pair Encoder

This block sits in front of a dual-mode multiplier that can perform either one 8-bit by 8-bit product or two independent 4-bit by 8-bit products. Each cycle it accepts a pair of unsigned 8-bit activations. It emits two 4-bit data nibbles, a left-shift code for each nibble and a 2-bit select field. The select field tells the multiplier which weight, or which weights, the nibbles pair with.

When one activation of the pair is zero, the other activation keeps all of its precision. It is split into a high nibble carrying shift 4 and a low nibble carrying shift 0, and both nibbles pair with the same weight. When both activations are non-zero, each is cut down to a 4-bit window placed by its most significant set bit. The window positions allowed are fixed at elaboration: five, three or two placements. An optional round-half-up step uses the first bit below the window. The data an output set encodes is always (nibble_a << shift_a) + (nibble_b << shift_b) per selected weight.

The block is one registered stage. Input valid is passed to output valid one cycle later, and the output registers load only on a valid input.

Top module: `act_pair_enc`

## Requirements
- R1: When act_b is zero, the output has sel=2'b01 (both nibbles belong to activation A): nib_a=act_a[7:4], sh_a=4, nib_b=act_a[3:0], sh_b=0.
- R2: When act_a is zero and act_b is non-zero, the output has sel=2'b10 (both nibbles belong to B): nib_a=act_b[7:4], sh_a=4, nib_b=act_b[3:0], sh_b=0.
- R3: When both activations are zero, the output is sel=2'b01 with both nibbles zero, sh_a=4 and sh_b=0.
- R4: When both activations are non-zero, sel=2'b00. Each activation is encoded on its own lane (A on nib_a/sh_a, B on nib_b/sh_b), and no trimmed nibble is zero.
- R5: With NUM_OPT=5 the shift of a trimmed value is max(0, p-3), where p is the bit index of its most significant one. With that shift, a trimmed nibble with non-zero shift has its top bit set.
- R6: With NUM_OPT=3 the shift is the smallest of {0,2,4} for which the window covers p. With NUM_OPT=2 it is the smaller of {0,4} that covers p. For example, 8'b00011011 gives shift 1, 2 and 4 in the three modes.
- R7: With ROUND_EN=1 and a shift s>0, the nibble is (x>>s) plus bit s-1 of x. With ROUND_EN=0, or when s=0, the nibble is x>>s truncated.
- R8: If rounding carries past 4 bits, the nibble saturates to 4'hF and the shift stays at the value chosen in R5/R6.
- R9: out_valid equals in_valid delayed by one cycle. While in_valid is low, the data outputs keep their previous values.
- R10: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair is valid |
| act_a | input | 8 | First unsigned activation |
| act_b | input | 8 | Second unsigned activation |
| out_valid | output | 1 | Registered valid |
| sel | output | 2 | 00 two trimmed lanes, 01 full A, 10 full B |
| nib_a | output | 4 | Nibble of lane A |
| sh_a | output | 3 | Left shift for nib_a |
| nib_b | output | 4 | Nibble of lane B |
| sh_b | output | 3 | Left shift for nib_b |

## Verification
The bench builds three copies side by side on the same inputs. The first has five placements with rounding, the second three placements with rounding, and the third two placements without rounding. This brings every window-selection rule and both the rounded and truncated nibble paths into reach with one stimulus stream. Saturation is reached through values whose window is all ones with a set guard bit, such as 8'hFF and 8'h1F. The zero-partner, both-zero and hold-while-idle cases are checked on all three copies.

// File: rtl/act_pair_enc.sv
module act_pair_enc #(
  parameter int NUM_OPT  = 5,
  parameter int ROUND_EN = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] act_a,
  input  logic [7:0] act_b,
  output logic       out_valid,
  output logic [1:0] sel,
  output logic [3:0] nib_a,
  output logic [2:0] sh_a,
  output logic [3:0] nib_b,
  output logic [2:0] sh_b
);

  function automatic logic [6:0] trim(input logic [7:0] x);
    logic [2:0] p, s;
    logic [3:0] t;
    logic       g;
    logic [4:0] r;
    p = 3'd0;
    for (int i = 0; i < 8; i++)
      if (x[i]) p = i[2:0];
    if (NUM_OPT == 5)      s = (p > 3'd3) ? p - 3'd3 : 3'd0;
    else if (NUM_OPT == 3) s = (p > 3'd5) ? 3'd4 : (p > 3'd3) ? 3'd2 : 3'd0;
    else                   s = (p > 3'd3) ? 3'd4 : 3'd0;
    t = 4'(x >> s);
    g = (ROUND_EN != 0 && s != 3'd0) ? x[s - 3'd1] : 1'b0;
    r = {1'b0, t} + {4'd0, g};
    return {(r[4] ? 4'hF : r[3:0]), s};
  endfunction

  logic       za, zb;
  logic [6:0] ta, tb;
  logic [7:0] full;
  logic [1:0] sel_d;
  logic [3:0] na_d, nb_d;
  logic [2:0] sa_d, sb_d;

  assign za   = (act_a == 8'd0);
  assign zb   = (act_b == 8'd0);
  assign ta   = trim(act_a);
  assign tb   = trim(act_b);
  assign full = zb ? act_a : act_b;

  always_comb begin
    if (za || zb) begin
      sel_d = zb ? 2'b01 : 2'b10;
      na_d  = full[7:4];
      sa_d  = 3'd4;
      nb_d  = full[3:0];
      sb_d  = 3'd0;
    end else begin
      sel_d = 2'b00;
      na_d  = ta[6:3];
      sa_d  = ta[2:0];
      nb_d  = tb[6:3];
      sb_d  = tb[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sel       <= 2'b00;
      nib_a     <= 4'd0;
      sh_a      <= 3'd0;
      nib_b     <= 4'd0;
      sh_b      <= 3'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sel   <= sel_d;
        nib_a <= na_d;
        sh_a  <= sa_d;
        nib_b <= nb_d;
        sh_b  <= sb_d;
      end
    end
  end

endmodule

// File: rtl/act_pair_enc_chk.sv
module act_pair_enc_chk #(
  parameter int NUM_OPT = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [1:0] sel,
  input logic [3:0] nib_a,
  input logic [2:0] sh_a,
  input logic [3:0] nib_b,
  input logic [2:0] sh_b
);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(nib_a) && $stable(nib_b) && $stable(sel) && $stable(sh_a) && $stable(sh_b)));

  // R1
  sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(sel));

  // R2
  full_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel != 2'b00) |-> (sh_a == 3'd4 && sh_b == 3'd0));

  // R4
  trim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel == 2'b00) |-> (nib_a != 4'd0 && nib_b != 4'd0));

  // R5
  lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_OPT == 5 && out_valid && sel == 2'b00 && sh_a != 3'd0) |-> nib_a[3]);

  // R10
  always @(posedge clk)
    if (!rst_n) reset_zero_chk: assert (!out_valid || $isunknown(out_valid));

endmodule

bind act_pair_enc act_pair_enc_chk #(.NUM_OPT(NUM_OPT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .sel(sel), .nib_a(nib_a), .sh_a(sh_a), .nib_b(nib_b), .sh_b(sh_b));

// File: tb/sim_act_pair_enc.sv
`timescale 1ns/1ps
module sim_act_pair_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] act_a = 8'd0, act_b = 8'd0;
  always #4 clk = ~clk;

  logic       ov [3];
  logic [1:0] sl [3];
  logic [3:0] na [3], nb [3];
  logic [2:0] sa [3], sb [3];

  act_pair_enc #(.NUM_OPT(5), .ROUND_EN(1)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .act_a(act_a), .act_b(act_b), .out_valid(ov[0]), .sel(sl[0]), .nib_a(na[0]), .sh_a(sa[0]), .nib_b(nb[0]), .sh_b(sb[0]));
  act_pair_enc #(.NUM_OPT(3), .ROUND_EN(1)) u1 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .act_a(act_a), .act_b(act_b), .out_valid(ov[1]), .sel(sl[1]), .nib_a(na[1]), .sh_a(sa[1]), .nib_b(nb[1]), .sh_b(sb[1]));
  act_pair_enc #(.NUM_OPT(2), .ROUND_EN(0)) u2 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .act_a(act_a), .act_b(act_b), .out_valid(ov[2]), .sel(sl[2]), .nib_a(na[2]), .sh_a(sa[2]), .nib_b(nb[2]), .sh_b(sb[2]));

  int total = 0, bad = 0;
  int opts [3] = '{5, 3, 2};
  int rnds [3] = '{1, 1, 0};

  // reference: smallest allowed shift whose window reaches x, then round/saturate
  function automatic int ref_shift(int x, int nopt);
    int cand [5];
    int n;
    if (nopt == 5) begin cand = '{0, 1, 2, 3, 4}; n = 5; end
    else if (nopt == 3) begin cand = '{0, 2, 4, 0, 0}; n = 3; end
    else begin cand = '{0, 4, 0, 0, 0}; n = 2; end
    for (int k = 0; k < n; k++)
      if (x < (16 << cand[k])) return cand[k];
    return cand[n-1];
  endfunction

  function automatic int ref_nib(int x, int nopt, int rnd);
    int s, v;
    s = ref_shift(x, nopt);
    v = x / (1 << s);
    if (rnd != 0 && s > 0 && ((x / (1 << (s - 1))) % 2) == 1) v = v + 1;
    if (v > 15) v = 15;
    return v;
  endfunction

  task automatic chk(string req, int k, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s inst%0d: actual=%0d expected=%0d (a=%0d b=%0d)", req, k, act, exp, act_a, act_b);
    end
  endtask

  task automatic send(int a, int b);
    @(negedge clk);
    act_a = 8'(a); act_b = 8'(b); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_all(string req);
    int a, b;
    a = act_a; b = act_b;
    for (int k = 0; k < 3; k++) begin
      chk({req, " valid"}, k, ov[k], 1);
      if (b == 0) begin
        chk({req, " R1/R3 sel"}, k, sl[k], 1);
        chk({req, " R1 hi"}, k, {na[k], sa[k]}, (a / 16) * 8 + 4);
        chk({req, " R1 lo"}, k, {nb[k], sb[k]}, (a % 16) * 8);
      end else if (a == 0) begin
        chk({req, " R2 sel"}, k, sl[k], 2);
        chk({req, " R2 hi"}, k, {na[k], sa[k]}, (b / 16) * 8 + 4);
        chk({req, " R2 lo"}, k, {nb[k], sb[k]}, (b % 16) * 8);
      end else begin
        chk({req, " R4 sel"}, k, sl[k], 0);
        chk({req, " R5/R6 sh_a"}, k, sa[k], ref_shift(a, opts[k]));
        chk({req, " R7/R8 nib_a"}, k, na[k], ref_nib(a, opts[k], rnds[k]));
        chk({req, " R5/R6 sh_b"}, k, sb[k], ref_shift(b, opts[k]));
        chk({req, " R7/R8 nib_b"}, k, nb[k], ref_nib(b, opts[k], rnds[k]));
      end
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++)
      chk("R10 reset", k, {ov[k], sl[k], na[k], sa[k], nb[k], sb[k]}, 0);
  endtask

  task automatic t_example();
    send(8'b00011011, 8'h01);
    check_all("R6 example");
    chk("R6 5opt sh", 0, sa[0], 1); chk("R7 5opt nib", 0, na[0], 14);
    chk("R6 3opt sh", 1, sa[1], 2); chk("R7 3opt nib", 1, na[1], 7);
    chk("R6 2opt sh", 2, sa[2], 4); chk("R7 2opt trunc", 2, na[2], 1);
  endtask

  task automatic t_zero_partner();
    send(8'hA7, 8'h00); check_all("R1");
    send(8'h00, 8'h5C); check_all("R2");
    send(8'h00, 8'h00); check_all("R3");
    for (int k = 0; k < 3; k++) chk("R3 zero nibbles", k, {na[k], nb[k]}, 0);
  endtask

  task automatic t_saturate();
    send(8'hFF, 8'h1F); check_all("R8");
    chk("R8 5opt sat a", 0, {na[0], sa[0]}, 15 * 8 + 4);
    chk("R8 5opt sat b", 0, {nb[0], sb[0]}, 15 * 8 + 1);
    send(8'h3F, 8'h0F); check_all("R8 3opt");
    chk("R8 3opt sat", 1, {na[1], sa[1]}, 15 * 8 + 2);
  endtask

  task automatic t_sweep();
    for (int i = 1; i <= 60; i++) begin
      send((i * 37 + 3) % 256, (i * 91 + 11) % 256);
      check_all("R4 sweep");
    end
    for (int p = 0; p < 8; p++) begin
      send(1 << p, (2 << p) - 1);
      check_all("R5 msb");
    end
  endtask

  task automatic t_hold();
    logic [13:0] prev [3];
    send(8'h6D, 8'h2B);
    for (int k = 0; k < 3; k++) prev[k] = {sl[k], na[k], sa[k], nb[k], sb[k]};
    act_a = 8'h00; act_b = 8'hF0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R9 valid low", k, ov[k], 0);
      chk("R9 hold", k, {sl[k], na[k], sa[k], nb[k], sb[k]}, prev[k]);
    end
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_example();
    t_zero_partner();
    t_saturate();
    t_sweep();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule